// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block gathers interrupt requests from eight peripheral lines and presents a single interrupt signal to a processor. A request is latched when its line rises. The controller keeps a per-line mask and a record of which levels are being serviced. It signals the processor only when an unmasked request outranks every level already in service. Line 0 has the highest priority and line 7 the lowest.

The processor answers with two acknowledge pulses. The first pulse moves the winning request from pending to in-service. The second pulse makes the controller return an 8-bit vector, so the processor finds the service routine without a fixed entry address. The vector is a programmed base in the upper five bits with the 3-bit level number below it. The processor writes commands and reads status through an 8-bit data path. A single address select and separate read and write strobes choose what is accessed. Every strobe is a single-cycle, active-high pulse sampled on the rising clock edge. Read data is registered and appears on the cycle after the strobe.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A pending bit is set only when its request line goes from low to high between two clock edges. A line that stays high after it has been acknowledged does not set its pending bit again.
- R2: A pending request whose mask bit is 1 does not raise `int_out`. It stays pending and can still be seen in the pending status.
- R3: `int_out` is high exactly when no acknowledge sequence is half done and some pending, unmasked line has a lower index than every in-service line.
- R4: Priority is fixed, with the lowest index winning. If several lines qualify, the first acknowledge pulse picks the lowest-numbered one.
- R5: The first acknowledge pulse clears the winner's pending bit and sets its in-service bit.
- R6: On the cycle after the second acknowledge pulse, `rdata` equals {base[4:0], level[2:0]}.
- R7: A write with `addr_sel`=0 and `wdata[2:0]`=3'b010 (end of interrupt) clears the lowest-numbered in-service bit.
- R8: A write with `addr_sel`=0 and `wdata[2:0]`=3'b001 loads the vector base from `wdata[7:3]`. Any other code at `addr_sel`=0 other than 3'b010 changes nothing.
- R9: A write with `addr_sel`=1 loads the mask register from `wdata`, one bit per line.
- R10: A read strobe gives the pending bits (`addr_sel`=0) or the in-service bits (`addr_sel`=1) on `rdata` in the next cycle. With no strobe and no vector cycle, `rdata` is 0.
- R11: A first acknowledge pulse with no qualifying request leaves the in-service bits unchanged, and the vector that follows carries level 7.
- R12: After reset, mask, base, pending and in-service are all 0, and `int_out` and `rdata` are 0.
- R13: `int_out` stays low between the first and the second acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_sel | input | 1 | Selects the command or status word |
| wr_stb | input | 1 | Write pulse |
| rd_stb | input | 1 | Read pulse |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Registered status or vector data |
| req_in | input | 8 | Peripheral request lines, index 0 highest |
| inta_in | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt to the processor |

## Verification
The hardest state to reach from the ports is nesting. A lower-priority request has to wait behind an in-service level, and later an end-of-interrupt command has to release it. Reaching that needs rising request edges, acknowledge pairs and end-of-interrupt writes in a careful order. The directed sequence builds two nested levels with a third request blocked underneath them, then unwinds them one command at a time. A random phase follows, in which a behavioural model shadows every clock edge while strobes, masks and request lines change freely.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NLINES = 8;
    localparam int LVL_W  = $clog2(NLINES);
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - LVL_W;

    typedef logic [NLINES-1:0] line_vec_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [BASE_W-1:0] base_t;

    typedef enum logic {ACK_IDLE = 1'b0, ACK_WAIT = 1'b1} ack_st_t;

    localparam logic [2:0] OP_BASE = 3'b001;
    localparam logic [2:0] OP_EOI  = 3'b010;

    typedef struct packed {
        logic      found;
        lvl_t      lvl;
        line_vec_t onehot;
    } grant_t;

    function automatic line_vec_t lowest_bit(line_vec_t v);
        return v & (~v + 1'b1);
    endfunction

    // lines strictly ahead of the highest-priority set bit; all lines if empty
    function automatic line_vec_t below_lowest(line_vec_t v);
        if (v == '0) return '1;
        return lowest_bit(v) - 1'b1;
    endfunction

    function automatic line_vec_t drop_lowest(line_vec_t v);
        return v & (v - 1'b1);
    endfunction

    function automatic lvl_t onehot_idx(line_vec_t v);
        lvl_t r = '0;
        for (int i = 0; i < NLINES; i++)
            if (v[i]) r = lvl_t'(i);
        return r;
    endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t req_in,
    input  line_vec_t clr,
    output line_vec_t pend_q
);
    line_vec_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req_in;
            pend_q <= (pend_q & ~clr) | (req_in & ~req_q);
        end
    end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
    import irq_pkg::*;
(
    input  line_vec_t pend,
    input  line_vec_t mask,
    input  line_vec_t isr,
    output grant_t    gnt
);
    line_vec_t cand;

    always_comb begin
        cand       = pend & ~mask & below_lowest(isr);
        gnt.onehot = lowest_bit(cand);
        gnt.found  = |cand;
        gnt.lvl    = onehot_idx(gnt.onehot);
    end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      inta,
    input  grant_t    gnt,
    input  logic      eoi,
    output line_vec_t is_q,
    output line_vec_t take,
    output logic      ack_wait,
    output lvl_t      lvl_q,
    output logic      vec_now
);
    ack_st_t st_q;
    logic    first;

    assign first    = inta && (st_q == ACK_IDLE);
    assign vec_now  = inta && (st_q == ACK_WAIT);
    assign ack_wait = (st_q == ACK_WAIT);
    assign take     = (first && gnt.found) ? gnt.onehot : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ACK_IDLE;
            is_q  <= '0;
            lvl_q <= '0;
        end else begin
            is_q <= (eoi ? drop_lowest(is_q) : is_q) | take;
            if (first) begin
                st_q  <= ACK_WAIT;
                lvl_q <= gnt.found ? gnt.lvl : '1;
            end else if (vec_now) begin
                st_q <= ACK_IDLE;
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_sel,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NLINES-1:0] req_in,
    input  logic              inta_in,
    output logic              int_out
);
    line_vec_t         mask_q, pend_q, is_q, take;
    base_t             base_q;
    grant_t            gnt;
    logic              ack_wait, vec_now, eoi;
    lvl_t              lvl_q;
    logic [DATA_W-1:0] rdata_q;

    assign eoi = wr_stb && !addr_sel && (wdata[2:0] == OP_EOI);

    irq_pend u_pend (
        .clk(clk), .rst(rst), .req_in(req_in), .clr(take), .pend_q(pend_q)
    );

    irq_resolve u_res (
        .pend(pend_q), .mask(mask_q), .isr(is_q), .gnt(gnt)
    );

    irq_ack_seq u_ack (
        .clk(clk), .rst(rst), .inta(inta_in), .gnt(gnt), .eoi(eoi),
        .is_q(is_q), .take(take), .ack_wait(ack_wait), .lvl_q(lvl_q),
        .vec_now(vec_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            base_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_stb && addr_sel)
                mask_q <= wdata;
            if (wr_stb && !addr_sel && (wdata[2:0] == OP_BASE))
                base_q <= wdata[DATA_W-1:LVL_W];
            if (vec_now)
                rdata_q <= {base_q, lvl_q};
            else if (rd_stb)
                rdata_q <= addr_sel ? is_q : pend_q;
            else
                rdata_q <= '0;
        end
    end

    assign rdata   = rdata_q;
    assign int_out = gnt.found && !ack_wait;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              addr_sel,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              inta_in,
    input logic              int_out,
    input logic              ack_wait,
    input line_vec_t         is_q,
    input line_vec_t         pend_q,
    input line_vec_t         mask_q,
    input base_t             base_q
);
    // R13
    wait_int_low_chk: assert property (@(posedge clk) disable iff (rst)
        ack_wait |-> !int_out);

    // R2
    masked_no_int_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~mask_q) == '0) |-> !int_out);

    // R5
    is_one_new_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(is_q & ~$past(is_q)) <= 1));

    // R7
    eoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !addr_sel && wdata[2:0] == OP_EOI && !inta_in)
        |=> (is_q == drop_lowest($past(is_q))));

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && !inta_in) |=> (rdata == '0));

    // R6
    vec_base_chk: assert property (@(posedge clk) disable iff (rst)
        (inta_in && ack_wait) |=> (rdata[DATA_W-1:LVL_W] == $past(base_q)));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata), .inta_in(inta_in),
    .int_out(int_out), .ack_wait(ack_wait), .is_q(is_q), .pend_q(pend_q),
    .mask_q(mask_q), .base_q(base_q)
);

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;
    logic       clk = 0, rst = 1;
    logic       addr_sel = 0, wr_stb = 0, rd_stb = 0, inta_in = 0;
    logic [7:0] wdata = 0, req_in = 0;
    logic [7:0] rdata;
    logic       int_out;
    int         checks = 0, errors = 0;
    logic       done = 0;

    always #2.5 clk = ~clk;

    irq_vec_ctrl u_irq_vec_ctrl (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata), .req_in(req_in),
        .inta_in(inta_in), .int_out(int_out)
    );

    // behavioural reference
    int m_pend, m_isr, m_mask, m_base, m_lvl, m_rdata, m_prev;
    bit m_wait;

    function automatic int m_winner(int p, int m, int s);
        int top_is = 8;
        for (int i = 7; i >= 0; i--) if (s[i]) top_is = i;
        for (int i = 0; i < 8; i++)
            if (p[i] && !m[i] && i < top_is) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_isr = 0; m_mask = 0; m_base = 0;
            m_lvl = 0; m_rdata = 0; m_prev = 0; m_wait = 0;
        end else begin
            int w, op, np, ns, nl, nr;
            bit nw;
            w = m_winner(m_pend, m_mask, m_isr);
            np = m_pend; ns = m_isr; nl = m_lvl; nw = m_wait;
            if (rd_stb) nr = addr_sel ? m_isr : m_pend; else nr = 0;
            op = wdata & 7;
            if (wr_stb && !addr_sel && op == 2)
                for (int i = 0; i < 8; i++) if (m_isr[i]) begin ns[i] = 0; break; end
            if (inta_in && !m_wait) begin
                if (w >= 0) begin np[w] = 0; ns[w] = 1; nl = w; end
                else nl = 7;
                nw = 1;
            end else if (inta_in && m_wait) begin
                nr = m_base * 8 + m_lvl;
                nw = 0;
            end
            if (wr_stb && addr_sel) m_mask = wdata;
            if (wr_stb && !addr_sel && op == 1) m_base = wdata >> 3;
            np = np | (req_in & ~m_prev & 8'hFF);
            m_prev = req_in;
            m_pend = np & 8'hFF; m_isr = ns; m_lvl = nl; m_wait = nw; m_rdata = nr;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle compare against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            int w;
            w = m_winner(m_pend, m_mask, m_isr);
            check("R3 int_out vs model", int_out, (w >= 0 && !m_wait) ? 1 : 0);
            check("R10 rdata vs model", rdata, m_rdata);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr_reg(bit a, logic [7:0] d);
        @(negedge clk); wr_stb = 1; addr_sel = a; wdata = d;
        @(negedge clk); wr_stb = 0;
    endtask
    task automatic rd_reg(bit a, output int v);
        @(negedge clk); rd_stb = 1; addr_sel = a;
        @(negedge clk); rd_stb = 0; v = rdata;
    endtask
    task automatic ack(output int v);
        @(negedge clk); inta_in = 1;
        @(negedge clk); inta_in = 0;
        check("R13 int low mid-sequence", int_out, 0);
        @(negedge clk); inta_in = 1;
        @(negedge clk); inta_in = 0; v = rdata;
    endtask
    task automatic set_req(logic [7:0] v);
        @(negedge clk); req_in = v;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R12 int after reset", int_out, 0);
        check("R12 rdata after reset", rdata, 0);
        rd_reg(0, v); check("R12 pending reset", v, 0);
        rd_reg(1, v); check("R12 in-service reset", v, 0);

        wr_reg(0, 8'hA9);            // base = 5'h15
        wr_reg(0, 8'hF3);            // unknown code, ignored (R8)
        set_req(8'h08); idle(1);
        check("R3 int on request", int_out, 1);
        rd_reg(0, v); check("R1 pending on rise", v, 8'h08);
        ack(v); check("R6 R8 vector level 3", v, 8'hAB);
        rd_reg(1, v); check("R5 in-service set", v, 8'h08);
        rd_reg(0, v); check("R5 pending cleared", v, 0);
        idle(2);
        check("R1 held line not relatched", int_out, 0);

        set_req(8'h28); idle(1);
        check("R3 lower level blocked", int_out, 0);
        rd_reg(0, v); check("R1 pending bit 5", v, 8'h20);
        set_req(8'h2A); idle(1);
        check("R3 higher level passes", int_out, 1);
        ack(v); check("R6 vector level 1", v, 8'hA9);
        rd_reg(1, v); check("R5 nested in-service", v, 8'h0A);
        wr_reg(0, 8'h02);
        rd_reg(1, v); check("R7 eoi clears level 1", v, 8'h08);
        check("R3 still blocked by 3", int_out, 0);
        wr_reg(0, 8'h02);
        rd_reg(1, v); check("R7 eoi clears level 3", v, 0);
        idle(1);
        check("R3 released after eoi", int_out, 1);
        ack(v); check("R6 vector level 5", v, 8'hAD);
        wr_reg(0, 8'h02);

        set_req(8'h00);
        wr_reg(1, 8'h04);
        set_req(8'h04); idle(1);
        check("R2 masked no int", int_out, 0);
        rd_reg(0, v); check("R2 masked stays pending", v, 8'h04);
        wr_reg(1, 8'h00); idle(1);
        check("R9 unmask raises int", int_out, 1);

        set_req(8'h85); idle(1);
        ack(v); check("R4 lowest index wins", v, 8'hA8);
        rd_reg(0, v); check("R4 others still pending", v, 8'h84);
        wr_reg(0, 8'h02);
        ack(v); check("R4 next is level 2", v, 8'hAA);
        wr_reg(0, 8'h02);
        ack(v); check("R4 then level 7", v, 8'hAF);
        wr_reg(0, 8'h02);
        set_req(8'h00); idle(1);
        ack(v); check("R11 spurious vector", v, 8'hAF);
        rd_reg(1, v); check("R11 in-service unchanged", v, 0);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            req_in   = ($urandom % 4 == 0) ? 8'($urandom) : req_in;
            inta_in  = ($urandom % 5 == 0);
            rd_stb   = ($urandom % 4 == 0);
            wr_stb   = ($urandom % 6 == 0);
            addr_sel = $urandom % 2;
            wdata    = ($urandom % 3 == 0) ? 8'h02 : 8'($urandom);
            if (wr_stb && addr_sel) wdata = ($urandom % 2) ? 8'h00 : 8'($urandom);
        end
        @(negedge clk);
        inta_in = 0; rd_stb = 0; wr_stb = 0;
        idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule